// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, together with the column and row of the pixel currently being shown inside the visible area. It runs from the pixel clock and makes one step per clock. Every line starts with the sync pulse, then the back porch, then the visible span, then the front porch. Frames are built from lines in the same order. All strobes are active high.

Software programs the geometry through a small write port. It writes four 32-bit timing words: two for the horizontal axis and two for the vertical axis. Each word packs a porch length and either a pulse width or a visible size. These writes only fill a shadow set. A commit request, made by writing bit 0 of the commit word, arms a transfer. The shadow set is then copied into the live set at the next frame boundary, which is the first clock of the vertical sync pulse. A raster that is already running therefore never sees a half-changed mode. The request is consumed by that copy and clears itself.

The timing loaded by reset is given by parameters. The defaults are a 1280x800 mode with totals of 1440 by 838.

Top module: `vtg_raster_core`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, the position is the first clock of line 0: `hsync_o`=1, `vsync_o`=1, `de_o`=0, `x_o`=0, `y_o`=0. The live and shadow sets both hold the parameter reset timing, and no commit is armed.
- R2: Each line lasts HSW+HBP+HACT+HFP clocks. `hsync_o` is high for the first HSW clocks. After HBP further clocks, the visible span lasts HACT clocks, and the front porch of HFP clocks follows.
- R3: Each frame lasts VSW+VBP+VACT+VFP lines. `vsync_o` is high for all clocks of the first VSW lines. The VBP back-porch lines follow, then VACT visible lines, then VFP front-porch lines.
- R4: `de_o` is high exactly when the horizontal position is in the visible span and the line is a visible line.
- R5: `x_o` counts 0..HACT-1 across the horizontally visible clocks of a line and is 0 elsewhere. `y_o` counts 0..VACT-1 across the visible lines and is 0 on other lines.
- R6: Horizontal word A (`cfg_sel`=0) carries HBP in bits 24:16 and HSW in bits 8:0. Horizontal word B (`cfg_sel`=1) carries HFP in bits 24:16 and HACT in bits 10:0. All other bits are ignored.
- R7: Vertical word A (`cfg_sel`=2) carries VBP in bits 23:16 and VSW in bits 7:0. Vertical word B (`cfg_sel`=3) carries VFP in bits 23:16 and VACT in bits 10:0. All other bits are ignored.
- R8: A timing-word write only changes the shadow set. Without a commit, the raster keeps its live timing indefinitely.
- R9: A write to `cfg_sel`=4 with bit 0 set arms a commit. At the last clock of the next frame, the shadow contents are copied, and the new timing applies from the first clock of the following frame. A commit write made in that last clock itself is deferred by one frame. A write to `cfg_sel`=4 with bit 0 clear has no effect.
- R10: An armed commit clears itself when it is applied. Shadow writes made afterwards stay unused until another commit is requested.
- R11: Writes with `cfg_sel` of 5, 6 or 7 have no effect on the raster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock, one raster step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 3 | Word select: 0..3 timing words, 4 commit |
| cfg_wdata | input | 32 | Write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable, high on visible pixels |
| x_o | output | 12 | Column inside the visible span, else 0 |
| y_o | output | 12 | Row inside the visible lines, else 0 |

## Verification
The properties take for granted that both sync widths are at least 1 and that each visible size is at least 1. Under those limits every line and frame begins inside a sync pulse, so a change of `vsync_o` or `y_o` must coincide with `hsync_o`, and `de_o` can never overlap a sync pulse. The stimulus draws all random sync widths from 1 upward and all visible sizes from 1 upward, and it leaves porches free to be zero. It fills the unused bits of every word with random junk and places commits at random clocks, so some of them land on the last clock of a frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Field widths fixed by the packed word layout
  localparam int HP_W  = 9;   // horizontal pulse and porch fields
  localparam int VP_W  = 8;   // vertical pulse and porch fields
  localparam int ACT_W = 11;  // visible width and height fields

  // Bit positions of the packed fields (decoded by software)
  localparam int PORCH_LSB = 16;
  localparam int HPORCH_MSB = PORCH_LSB + HP_W - 1;  // 24
  localparam int VPORCH_MSB = PORCH_LSB + VP_W - 1;  // 23

  typedef struct packed {
    logic [HP_W-1:0]  hsw;
    logic [HP_W-1:0]  hbp;
    logic [ACT_W-1:0] hact;
    logic [HP_W-1:0]  hfp;
    logic [VP_W-1:0]  vsw;
    logic [VP_W-1:0]  vbp;
    logic [ACT_W-1:0] vact;
    logic [VP_W-1:0]  vfp;
  } vtg_timing_t;

  typedef enum logic [2:0] {
    SEL_HWORD_A = 3'd0,
    SEL_HWORD_B = 3'd1,
    SEL_VWORD_A = 3'd2,
    SEL_VWORD_B = 3'd3,
    SEL_COMMIT  = 3'd4
  } vtg_sel_e;

endpackage

// File: rtl/vtg_shadow_regs.sv
module vtg_shadow_regs
  import vtg_pkg::*;
#(
  parameter vtg_timing_t RESET_SET = '0
) (
  input  logic        clk_pix,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        frame_wrap,
  output vtg_timing_t live_o,
  output logic        pend_o
);

  vtg_timing_t shadow_q, shadow_d;
  vtg_timing_t live_q, live_d;
  logic        pend_q, pend_d;
  logic        shadow_en, live_en, pend_en;
  logic        commit_req;
  logic        unused_wdata_bits;

  assign unused_wdata_bits = ^{wr_data[31:25], wr_data[15:11]};

  // Shadow set: decode of the packed timing words
  always_comb begin
    shadow_d  = shadow_q;
    shadow_en = 1'b0;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_HWORD_A: begin
          shadow_d.hbp = wr_data[HPORCH_MSB:PORCH_LSB];
          shadow_d.hsw = wr_data[HP_W-1:0];
          shadow_en    = 1'b1;
        end
        SEL_HWORD_B: begin
          shadow_d.hfp  = wr_data[HPORCH_MSB:PORCH_LSB];
          shadow_d.hact = wr_data[ACT_W-1:0];
          shadow_en     = 1'b1;
        end
        SEL_VWORD_A: begin
          shadow_d.vbp = wr_data[VPORCH_MSB:PORCH_LSB];
          shadow_d.vsw = wr_data[VP_W-1:0];
          shadow_en    = 1'b1;
        end
        SEL_VWORD_B: begin
          shadow_d.vfp  = wr_data[VPORCH_MSB:PORCH_LSB];
          shadow_d.vact = wr_data[ACT_W-1:0];
          shadow_en     = 1'b1;
        end
        default: shadow_en = 1'b0;
      endcase
    end
  end

  // Commit request and frame-boundary transfer
  always_comb begin
    commit_req = wr_en && (wr_sel == SEL_COMMIT) && wr_data[0];
    pend_d     = commit_req | (pend_q & ~frame_wrap);
    pend_en    = commit_req | frame_wrap;
    live_en    = frame_wrap & pend_q;
    live_d     = shadow_q;
  end

  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RESET_SET;
      live_q   <= RESET_SET;
      pend_q   <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (live_en)   live_q   <= live_d;
      if (pend_en)   pend_q   <= pend_d;
    end
  end

  assign live_o = live_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int CNT_W = 12,
  parameter int LEN_W = 9,
  parameter int ACT_W = 11
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             step,
  input  logic [LEN_W-1:0] sync_len,
  input  logic [LEN_W-1:0] back_len,
  input  logic [ACT_W-1:0] act_len,
  input  logic [LEN_W-1:0] front_len,
  output logic             at_end,
  output logic             in_sync,
  output logic             in_active,
  output logic [CNT_W-1:0] pos
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] span_start, span_stop, span_total;
  logic [CNT_W-1:0] rel;

  // Segment boundaries: sync, back porch, visible, front porch
  always_comb begin
    span_start = CNT_W'(sync_len) + CNT_W'(back_len);
    span_stop  = span_start + CNT_W'(act_len);
    span_total = span_stop + CNT_W'(front_len);
    at_end     = (cnt_q == span_total - CNT_W'(1));
    in_sync    = (cnt_q < CNT_W'(sync_len));
    in_active  = (cnt_q >= span_start) && (cnt_q < span_stop);
    rel        = cnt_q - span_start;
    pos        = in_active ? rel : '0;
    cnt_d      = at_end ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vtg_raster_core.sv
module vtg_raster_core
  import vtg_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int RST_HSW  = 40,
  parameter int RST_HBP  = 40,
  parameter int RST_HACT = 1280,
  parameter int RST_HFP  = 80,
  parameter int RST_VSW  = 10,
  parameter int RST_VBP  = 14,
  parameter int RST_VACT = 800,
  parameter int RST_VFP  = 14
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [CNT_W-1:0] x_o,
  output logic [CNT_W-1:0] y_o
);

  localparam vtg_timing_t RESET_SET = '{
    hsw:  HP_W'(RST_HSW),
    hbp:  HP_W'(RST_HBP),
    hact: ACT_W'(RST_HACT),
    hfp:  HP_W'(RST_HFP),
    vsw:  VP_W'(RST_VSW),
    vbp:  VP_W'(RST_VBP),
    vact: ACT_W'(RST_VACT),
    vfp:  VP_W'(RST_VFP)
  };

  vtg_timing_t      live;
  logic             commit_pend;
  logic             frame_wrap;
  logic             h_end, h_sync, h_act;
  logic             v_end, v_sync, v_act;
  logic [CNT_W-1:0] h_pos, v_pos;

  assign frame_wrap = h_end & v_end;

  vtg_shadow_regs #(.RESET_SET(RESET_SET)) u_regs (
    .clk_pix    (clk_pix),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wr_sel     (cfg_sel),
    .wr_data    (cfg_wdata),
    .frame_wrap (frame_wrap),
    .live_o     (live),
    .pend_o     (commit_pend)
  );

  vtg_axis #(.CNT_W(CNT_W), .LEN_W(HP_W), .ACT_W(ACT_W)) u_haxis (
    .clk_pix   (clk_pix),
    .rst_n     (rst_n),
    .step      (1'b1),
    .sync_len  (live.hsw),
    .back_len  (live.hbp),
    .act_len   (live.hact),
    .front_len (live.hfp),
    .at_end    (h_end),
    .in_sync   (h_sync),
    .in_active (h_act),
    .pos       (h_pos)
  );

  vtg_axis #(.CNT_W(CNT_W), .LEN_W(VP_W), .ACT_W(ACT_W)) u_vaxis (
    .clk_pix   (clk_pix),
    .rst_n     (rst_n),
    .step      (h_end),
    .sync_len  (live.vsw),
    .back_len  (live.vbp),
    .act_len   (live.vact),
    .front_len (live.vfp),
    .at_end    (v_end),
    .in_sync   (v_sync),
    .in_active (v_act),
    .pos       (v_pos)
  );

  assign hsync_o = h_sync;
  assign vsync_o = v_sync;
  assign de_o    = h_act & v_act;
  assign x_o     = h_pos;
  assign y_o     = v_pos;

endmodule

// File: rtl/vtg_raster_checker.sv
module vtg_raster_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk_pix,
  input logic             rst_n,
  input logic             commit_req,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic [CNT_W-1:0] x_o,
  input logic [CNT_W-1:0] y_o,
  input logic             pend,
  input logic             frame_wrap
);

  assert_de_outside_sync_R4: assert property (@(posedge clk_pix) disable iff (!rst_n)
    de_o |-> (!hsync_o && !vsync_o));

  assert_x_zero_in_sync_R2: assert property (@(posedge clk_pix) disable iff (!rst_n)
    hsync_o |-> (x_o == '0));

  assert_x_steps_R5: assert property (@(posedge clk_pix) disable iff (!rst_n)
    de_o |=> (!de_o || (x_o == $past(x_o) + CNT_W'(1))));

  assert_vsync_on_line_start_R3: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !$stable(vsync_o) |-> hsync_o);

  assert_y_on_line_start_R5: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !$stable(y_o) |-> hsync_o);

  assert_commit_arms_R9: assert property (@(posedge clk_pix) disable iff (!rst_n)
    commit_req |=> pend);

  assert_commit_clears_R10: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (pend && frame_wrap) |=> (!pend || $past(commit_req)));

endmodule

bind vtg_raster_core vtg_raster_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_pix    (clk_pix),
  .rst_n      (rst_n),
  .commit_req (cfg_wr && (cfg_sel == 3'd4) && cfg_wdata[0]),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .x_o        (x_o),
  .y_o        (y_o),
  .pend       (commit_pend),
  .frame_wrap (frame_wrap)
);

// File: tb/vtg_raster_core_tb_top.sv
module vtg_raster_core_tb_top;

  localparam int CW = 12;

  logic          clk_pix = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_sel = 3'd0;
  logic [31:0]   cfg_wdata = 32'd0;
  logic          hsync_o, vsync_o, de_o;
  logic [CW-1:0] x_o, y_o;

  always #4 clk_pix = ~clk_pix;  // 125 MHz

  vtg_raster_core #(
    .CNT_W(CW),
    .RST_HSW(3), .RST_HBP(2), .RST_HACT(6), .RST_HFP(2),
    .RST_VSW(2), .RST_VBP(1), .RST_VACT(4), .RST_VFP(1)
  ) dut_i (
    .clk_pix(clk_pix), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .x_o(x_o), .y_o(y_o)
  );

  typedef struct {
    int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
  } tm_t;

  tm_t   m_live, m_shadow;
  bit    m_pend;
  int    mh, mv;
  int    n_checks = 0;
  int    n_fail = 0;
  string ctx = "R1";

  function automatic int htot(tm_t t); return t.hsw + t.hbp + t.hact + t.hfp; endfunction
  function automatic int vtot(tm_t t); return t.vsw + t.vbp + t.vact + t.vfp; endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d (h=%0d v=%0d)",
               req, ctx, what, act, exp, mh, mv);
    end
  endtask

  task automatic compare();
    int  hs0, hs1, vs0, vs1;
    bit  ha, va;
    hs0 = m_live.hsw + m_live.hbp; hs1 = hs0 + m_live.hact;
    vs0 = m_live.vsw + m_live.vbp; vs1 = vs0 + m_live.vact;
    ha  = (mh >= hs0) && (mh < hs1);
    va  = (mv >= vs0) && (mv < vs1);
    chk("R2", "hsync", int'(hsync_o), int'(mh < m_live.hsw));
    chk("R3", "vsync", int'(vsync_o), int'(mv < m_live.vsw));
    chk("R4", "de", int'(de_o), int'(ha && va));
    chk("R5", "x", int'(x_o), ha ? mh - hs0 : 0);
    chk("R5", "y", int'(y_o), va ? mv - vs0 : 0);
  endtask

  // One clock: compare at negedge, drive inputs, advance the model over the next posedge
  task automatic cycle(input bit we, input logic [2:0] sel, input logic [31:0] d);
    bit  hend, wrap;
    tm_t nlive;
    @(negedge clk_pix);
    compare();
    if (!rst_n) rst_n = 1'b1;
    cfg_wr = we; cfg_sel = sel; cfg_wdata = d;
    hend  = (mh == htot(m_live) - 1);
    wrap  = hend && (mv == vtot(m_live) - 1);
    nlive = (wrap && m_pend) ? m_shadow : m_live;
    m_pend = (we && sel == 3'd4 && d[0]) || (m_pend && !wrap);
    if (we) begin
      case (sel)
        3'd0: begin m_shadow.hbp = int'(d[24:16]); m_shadow.hsw  = int'(d[8:0]);  end
        3'd1: begin m_shadow.hfp = int'(d[24:16]); m_shadow.hact = int'(d[10:0]); end
        3'd2: begin m_shadow.vbp = int'(d[23:16]); m_shadow.vsw  = int'(d[7:0]);  end
        3'd3: begin m_shadow.vfp = int'(d[23:16]); m_shadow.vact = int'(d[10:0]); end
        default: ;
      endcase
    end
    if (hend) begin
      mh = 0;
      mv = wrap ? 0 : mv + 1;
    end else begin
      mh = mh + 1;
    end
    m_live = nlive;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 32'd0);
  endtask

  function automatic logic [31:0] pack(input logic [31:0] junk, input logic [31:0] mask,
                                       input int hi, input int lo);
    return (junk & ~mask) | (32'(hi) << 16) | 32'(lo);
  endfunction

  task automatic wr_timing(input tm_t t);
    cycle(1'b1, 3'd0, pack($urandom, 32'h01FF_01FF, t.hbp, t.hsw));
    cycle(1'b1, 3'd1, pack($urandom, 32'h01FF_07FF, t.hfp, t.hact));
    cycle(1'b1, 3'd2, pack($urandom, 32'h00FF_00FF, t.vbp, t.vsw));
    cycle(1'b1, 3'd3, pack($urandom, 32'h00FF_07FF, t.vfp, t.vact));
  endtask

  function automatic tm_t rand_tm();
    tm_t t;
    t.hsw = 1 + int'($urandom % 4); t.hbp = int'($urandom % 4);
    t.hact = 1 + int'($urandom % 8); t.hfp = int'($urandom % 4);
    t.vsw = 1 + int'($urandom % 2); t.vbp = int'($urandom % 3);
    t.vact = 1 + int'($urandom % 4); t.vfp = int'($urandom % 3);
    return t;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk_pix);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
    $finish;
  end

  initial begin
    tm_t t;
    void'($urandom(32'h0007_1e55));
    m_live = '{hsw: 3, hbp: 2, hact: 6, hfp: 2, vsw: 2, vbp: 1, vact: 4, vfp: 1};
    m_shadow = m_live;
    m_pend = 1'b0;
    mh = 0;
    mv = 0;
    repeat (3) @(posedge clk_pix);

    // R1: reset state, then first frames with the reset timing (R2, R3)
    @(negedge clk_pix);
    chk("R1", "hsync in reset", int'(hsync_o), 1);
    chk("R1", "vsync in reset", int'(vsync_o), 1);
    chk("R1", "de in reset", int'(de_o), 0);
    chk("R1", "x in reset", int'(x_o), 0);
    chk("R1", "y in reset", int'(y_o), 0);
    ctx = "R1 R2 R3";
    idle(2 * 13 * 8);

    // R8: shadow writes alone never reach the raster
    ctx = "R8";
    t = '{hsw: 2, hbp: 1, hact: 5, hfp: 3, vsw: 1, vbp: 2, vact: 3, vfp: 2};
    wr_timing(t);
    idle(3 * 13 * 8);

    // R9: commit word with bit 0 clear does nothing; with bit 0 set applies at frame edge
    ctx = "R9";
    cycle(1'b1, 3'd4, 32'hFFFF_FFFE);
    idle(2 * 13 * 8);
    cycle(1'b1, 3'd4, 32'h0000_0001);
    idle(3 * 13 * 8);

    // R10: commit consumed, later shadow writes stay pending
    ctx = "R10";
    wr_timing('{hsw: 4, hbp: 0, hact: 2, hfp: 0, vsw: 2, vbp: 0, vact: 1, vfp: 0});
    idle(4 * 11 * 7);

    // R11: unused selects have no effect
    ctx = "R11";
    for (int s = 5; s < 8; s++) cycle(1'b1, 3'(s), $urandom | 32'h1);
    idle(3 * 11 * 7);

    // R6 R7 R9 R10: random programming, random commit placement
    ctx = "R6 R7 R9 R10";
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0, 1: wr_timing(rand_tm());
        2: cycle(1'b1, 3'd4, $urandom);
        3: cycle(1'b1, 3'(5 + int'($urandom % 3)), $urandom);
        default: begin
          wr_timing(rand_tm());
          cycle(1'b1, 3'd4, 32'h1);
        end
      endcase
      idle(int'($urandom % 300));
    end

    // Directed: commit in the last clock of a frame is deferred one frame (R9)
    ctx = "R9 last-clock commit";
    wr_timing(rand_tm());
    while (!((mh == htot(m_live) - 1) && (mv == vtot(m_live) - 1))) idle(1);
    cycle(1'b1, 3'd4, 32'h1);
    idle(3 * 19 * 10);

    summary();
    $finish;
  end

endmodule